// File: doc/BRIEF.md
# Wavefront Lane-Mask Controller

This block owns the active-lane mask of a 64-lane wavefront. Conditional code runs on every lane in lockstep: instead of branching, the program narrows the mask so that only lanes meeting a condition write results. A vector compare delivers one result bit per lane. The block then applies a short sequence of scalar mask steps. It saves the current mask into a scalar slot, keeps only the passing lanes for the "then" side, and forms the "else" lanes from the saved mask with the current lanes removed. At the end it copies the saved mask back.

Each mask step is registered, so its result shows one cycle after the operation is issued. Two skip flags tell the instruction front end when a side of the conditional has no live lane left, so that the whole body can be jumped over. There are eight save slots, which lets nested conditionals each keep their own mask.

Top module: `exec_mask_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it is released, the lane mask is all ones and both skip flags are low.
- R2: Operation code 1 (save) copies the current lane mask into the slot selected by the slot index, and leaves the lane mask unchanged.
- R3: Operation code 2 (then-entry) sets the lane mask to its old value AND the compare vector. The result is visible in the next cycle.
- R4: Operation code 3 (else-entry) sets the lane mask to the selected slot AND NOT the old lane mask. The result is visible in the next cycle.
- R5: Operation code 4 (restore) sets the lane mask to the contents of the selected slot. The result is visible in the next cycle.
- R6: Operation code 0 and codes 5, 6 and 7 change neither the lane mask nor any slot.
- R7: The then-skip flag is high exactly in the cycle after a then-entry whose resulting lane mask is all zeros. That is always the case when the compare vector was all zeros.
- R8: The else-skip flag is high exactly in the cycle after an else-entry whose resulting lane mask is all zeros.
- R9: The eight slots are independent. Saving into one slot does not disturb the others, so nested conditionals restore correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op | input | 3 | Mask operation code (0 none, 1 save, 2 then-entry, 3 else-entry, 4 restore) |
| slot_idx | input | 3 | Save slot used by save, else-entry and restore |
| vcc | input | 64 | Per-lane compare result |
| exec_mask | output | 64 | Current active-lane mask |
| skip_then | output | 1 | Then-body has no active lane |
| skip_else | output | 1 | Else-body has no active lane |

## Verification
The assertions take for granted that the operation code, slot index and compare vector are steady around each rising edge, and that one operation is issued per cycle. They do not assume the program is well formed: a restore from a slot never saved, or an else-entry without a matching save, must still behave as the requirements state. The stimulus drives every input on the falling edge. It issues random codes across all eight values, including the unused ones, together with random slots. Compare vectors are biased toward all-zero, all-one and sparse patterns so that both skip flags fire often. Directed nested if/else sequences are mixed in with the random stimulus.

// File: rtl/exec_mask_pkg.sv
// Package: shared operation encoding for the lane-mask controller.
// Assumes: codes 5..7 are unused and are treated as no-ops.
package exec_mask_pkg;
    typedef enum logic [2:0] {
        MOP_NONE    = 3'd0,
        MOP_SAVE    = 3'd1,
        MOP_THEN    = 3'd2,
        MOP_ELSE    = 3'd3,
        MOP_RESTORE = 3'd4
    } mask_op_e;
endpackage

// File: rtl/mask_slot_file.sv
// Module: bank of scalar save slots, each as wide as the lane mask.
// One write port and one asynchronous read port. Assumes at most one write per cycle.
module mask_slot_file #(
    parameter int LANES  = 64,
    parameter int SLOTS  = 8,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [LANES-1:0] wr_data,
    output logic [LANES-1:0] rd_data
);
    logic [LANES-1:0] slot_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        // Hold one saved mask; clear on reset, load on matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (wr_en && (idx == IDX_W'(g)))
                slot_q[g] <= wr_data;
        end
    end

    // Read the selected slot.
    assign rd_data = slot_q[idx];

    // R9: a written slot reads back its data in the next cycle when selected again.
    a_r9_slot_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(rst_n)) ##1 (idx == $past(idx)) |-> rd_data == $past(wr_data));
endmodule

// File: rtl/mask_skip_detect.sv
// Module: produces the then/else skip flags from the last operation and the live mask.
// Assumes the mask it sees is the one updated by that same last operation.
module mask_skip_detect #(
    parameter int LANES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op,
    input  logic [LANES-1:0] mask,
    output logic             skip_then,
    output logic             skip_else
);
    import exec_mask_pkg::*;

    logic was_then_q, was_else_q;

    // Remember which entry operation was issued last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            was_then_q <= 1'b0;
            was_else_q <= 1'b0;
        end else begin
            was_then_q <= (op == MOP_THEN);
            was_else_q <= (op == MOP_ELSE);
        end
    end

    // Flag a side as skippable when no lane survived its entry.
    assign skip_then = was_then_q && (mask == '0);
    assign skip_else = was_else_q && (mask == '0);

    // R7: the then-skip flag only follows a then-entry.
    a_r7_then_origin: assert property (@(posedge clk) disable iff (!rst_n)
        skip_then |-> $past(op) == MOP_THEN);
    // R8: the else-skip flag only follows an else-entry.
    a_r8_else_origin: assert property (@(posedge clk) disable iff (!rst_n)
        skip_else |-> $past(op) == MOP_ELSE);
    // R7/R8: the two flags never fire together.
    a_r7_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(skip_then && skip_else));
endmodule

// File: rtl/exec_mask_ctrl.sv
// Module: top of the lane-mask controller. It holds the active-lane mask, applies one
// mask operation per cycle, and exposes the skip flags. Assumes one operation per cycle.
module exec_mask_ctrl #(
    parameter int LANES  = 64,
    parameter int SLOTS  = 8,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op,
    input  logic [IDX_W-1:0] slot_idx,
    input  logic [LANES-1:0] vcc,
    output logic [LANES-1:0] exec_mask,
    output logic             skip_then,
    output logic             skip_else
);
    import exec_mask_pkg::*;

    logic [LANES-1:0] exec_q, exec_d, slot_rd;
    logic             save_en;

    assign save_en = (op == MOP_SAVE);

    mask_slot_file #(.LANES(LANES), .SLOTS(SLOTS)) u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (save_en),
        .idx     (slot_idx),
        .wr_data (exec_q),
        .rd_data (slot_rd)
    );

    // Select the next mask from the issued operation.
    always_comb begin
        exec_d = exec_q;
        case (op)
            MOP_THEN:    exec_d = exec_q & vcc;
            MOP_ELSE:    exec_d = slot_rd & ~exec_q;
            MOP_RESTORE: exec_d = slot_rd;
            default:     exec_d = exec_q;
        endcase
    end

    // Hold the active-lane mask; all lanes live after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            exec_q <= '1;
        else
            exec_q <= exec_d;
    end

    assign exec_mask = exec_q;

    mask_skip_detect #(.LANES(LANES)) u_skip (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .mask      (exec_q),
        .skip_then (skip_then),
        .skip_else (skip_else)
    );

    // R1: the mask leaves reset with every lane active.
    a_r1_reset_all_live: assert property (@(posedge clk)
        !rst_n |=> exec_mask == '1);
    // R3: a then-entry narrows the mask to passing lanes.
    a_r3_then_and: assert property (@(posedge clk) disable iff (!rst_n)
        op == MOP_THEN |=> exec_mask == ($past(exec_mask) & $past(vcc)));
    // R6: none-codes and unused codes hold the mask.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op == MOP_NONE || op > MOP_RESTORE) |=> $stable(exec_mask));
    // R2: a save leaves the mask untouched.
    a_r2_save_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
        op == MOP_SAVE |=> $stable(exec_mask));
    // R7: an all-zero compare on a then-entry must raise the then-skip flag.
    a_r7_vcc_zero_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (op == MOP_THEN && vcc == '0) |=> skip_then);
endmodule

// File: tb/tb_exec_mask_ctrl.sv
module tb_exec_mask_ctrl;
    localparam int LANES = 64;
    localparam int SLOTS = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       op = 3'd0;
    logic [2:0]       slot_idx = 3'd0;
    logic [LANES-1:0] vcc = '0;
    logic [LANES-1:0] exec_mask;
    logic             skip_then, skip_else;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic [LANES-1:0] m_exec;
    logic [LANES-1:0] m_slot [SLOTS];
    logic             m_st, m_se;

    always #2 clk = ~clk;

    exec_mask_ctrl #(.LANES(LANES), .SLOTS(SLOTS)) dut (
        .clk(clk), .rst_n(rst_n), .op(op), .slot_idx(slot_idx), .vcc(vcc),
        .exec_mask(exec_mask), .skip_then(skip_then), .skip_else(skip_else)
    );

    function automatic logic [LANES-1:0] next_exec(input logic [2:0] o,
            input logic [LANES-1:0] e, input logic [LANES-1:0] v, input logic [LANES-1:0] s);
        case (o)
            3'd2: return e & v;
            3'd3: return s & ~e;
            3'd4: return s;
            default: return e;
        endcase
    endfunction

    function automatic string op_tag(input logic [2:0] o);
        case (o)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [LANES-1:0] got, input logic [LANES-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Compare outputs with the model, then issue one operation (called at negedge).
    task automatic step(input logic [2:0] o, input logic [2:0] i, input logic [LANES-1:0] v);
        logic [2:0] prev;
        prev = op;
        chk(op_tag(prev), exec_mask, m_exec);
        chk("R7", {63'd0, skip_then}, {63'd0, m_st});
        chk("R8", {63'd0, skip_else}, {63'd0, m_se});
        op = o; slot_idx = i; vcc = v;
        m_st = (o == 3'd2) && (next_exec(o, m_exec, v, m_slot[i]) == '0);
        m_se = (o == 3'd3) && (next_exec(o, m_exec, v, m_slot[i]) == '0);
        if (o == 3'd1) m_slot[i] = m_exec;
        m_exec = next_exec(o, m_exec, v, m_slot[i]);
        @(negedge clk);
    endtask

    function automatic logic [LANES-1:0] rnd_vcc();
        int k;
        k = int'($urandom % 6);
        case (k)
            0: return '0;
            1: return '1;
            2: return {32'd0, $urandom} & {32'd0, $urandom};
            default: return {$urandom, $urandom};
        endcase
    endfunction

    initial begin
        int seed;
        seed = int'($urandom(32'd1234));
        for (int s = 0; s < SLOTS; s++) m_slot[s] = '0;
        m_exec = '1; m_st = 1'b0; m_se = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", exec_mask, '1);
        chk("R1", {62'd0, skip_then, skip_else}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", exec_mask, '1);
        chk("R1", {62'd0, skip_then, skip_else}, '0);
        // Directed: if/else with half lanes, then restore.
        step(3'd1, 3'd0, '0);
        step(3'd2, 3'd0, {32'hFFFF_FFFF, 32'h0});
        step(3'd3, 3'd0, '0);
        step(3'd4, 3'd0, '0);
        // Directed: all lanes fail (R7 skip), else gets all lanes.
        step(3'd1, 3'd2, '0);
        step(3'd2, 3'd2, '0);
        step(3'd3, 3'd2, '0);
        step(3'd4, 3'd2, '0);
        // Directed: all lanes pass, else empty (R8 skip).
        step(3'd1, 3'd3, '0);
        step(3'd2, 3'd3, '1);
        step(3'd3, 3'd3, '0);
        step(3'd4, 3'd3, '0);
        // Directed nesting across slots (R9) and unused codes (R6).
        step(3'd1, 3'd4, '0);
        step(3'd2, 3'd4, 64'h00FF_00FF_00FF_00FF);
        step(3'd1, 3'd5, '0);
        step(3'd2, 3'd5, 64'h0000_FFFF_0000_FFFF);
        step(3'd7, 3'd5, '1);
        step(3'd3, 3'd5, '0);
        step(3'd4, 3'd5, '0);
        step(3'd6, 3'd4, '0);
        step(3'd3, 3'd4, '0);
        step(3'd4, 3'd4, '0);
        step(3'd5, 3'd1, '0);
        step(3'd0, 3'd1, '0);
        // Random mix.
        for (int n = 0; n < 3000; n++)
            step(3'($urandom % 8), 3'($urandom % 8), rnd_vcc());
        step(3'd0, 3'd0, '0);
        step(3'd0, 3'd0, '0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule